// File: doc/BRIEF.md
# Windowed Register File

This block is the general-purpose register file of a processor core that gives each procedure its own view of the registers. Software always names 32 logical registers. Eight of them are globals shared by every procedure. The other 24 come from the currently visible window: 8 incoming parameters, 8 private locals and 8 outgoing parameters. A window pointer chooses that window. Physical storage holds the globals once, plus a block of ins and locals for each window.

A call strobe moves the pointer one window down. The caller's outgoing registers are then physically the callee's incoming registers, so arguments pass without any copying. A return strobe moves the pointer back up. An occupancy count tracks how many windows hold live procedure frames. A call with every window occupied raises an overflow trap, and a return from the last frame raises an underflow trap. In both cases the pointer stays where it is, so the spill or fill handler can run. That handler and its memory traffic are outside this block.

Reads are combinational, with two independent ports. A read that names the register being written in the same cycle returns the new data.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 0 to 7 are globals. They map to the same storage in every window, so a value written in one window reads back unchanged in any other window.
- R2: Logical registers 8 to 15 are the outs, 16 to 23 the locals and 24 to 31 the ins. The locals of one window are private: writing local k in one window leaves local k of every other window unchanged.
- R3: Outs register 8+k of window w and ins register 24+k of window (w-1) mod 4 name the same physical register.
- R4: An accepted call changes the window pointer `cwp_o` from w to (w-1) mod 4 at the next clock edge. An accepted return changes it to (w+1) mod 4.
- R5: After reset `cwp_o` is 0, one window is occupied and both trap outputs are low.
- R6: A call while all 4 windows are occupied drives `ovf_trap` high in that cycle. The pointer and the occupancy stay unchanged.
- R7: A return while only one window is occupied drives `unf_trap` high in that cycle. The pointer and the occupancy stay unchanged.
- R8: When call and return are asserted together, nothing happens: no pointer move and no trap.
- R9: A read of the register being written in the same cycle returns the write data (write-through bypass).
- R10: Reads and the write in a cycle use the window that is current at the start of that cycle. A call or return in the same cycle does not change that window.
- R11: The two read ports are independent. Each can return a different register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| call_i | input | 1 | Procedure call strobe: move to the next lower window |
| ret_i | input | 1 | Procedure return strobe: move back to the next higher window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Logical register for read port 0 |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Logical register for read port 1 |
| rd1_data | output | 32 | Read port 1 data |
| ovf_trap | output | 1 | Call refused because every window is occupied |
| unf_trap | output | 1 | Return refused because only one window is occupied |
| cwp_o | output | 2 | Current window pointer |

## Verification
Two functions can fall in the same clock cycle: a register access and a window move. The bench provokes this by issuing a write, or a read, in the very cycle that carries a call or return strobe. In the cycle after the call, it reads the callee's in register. If the write went through the caller's outs, that in register holds the data, and a read in the return cycle must still see the old window's local. A second overlap is a write and a read of the same register in one cycle. A third is a call and a return in one cycle. Each is judged at the read ports, the trap outputs and the pointer.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Register group, taken from the two top bits of a logical register number.
  typedef enum logic [1:0] {
    GRP_GLOB = 2'd0,
    GRP_OUT  = 2'd1,
    GRP_LOC  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;

endpackage

// File: rtl/regwin_rst_sync.sv
module regwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_q_n = sync_q;

endmodule

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int NGRP = 8,
  parameter int LW   = 5,
  parameter int PW   = 7,
  parameter int WW   = 2
) (
  input  logic [WW-1:0] cwp,
  input  logic [LW-1:0] laddr,
  output logic [PW-1:0] paddr
);

  localparam int OFF_W = $clog2(NGRP);

  grp_e             grp;
  logic [OFF_W-1:0] off;
  logic [WW-1:0]    win;
  logic             is_local;

  assign grp = grp_e'(laddr[LW-1 -: 2]);
  assign off = laddr[OFF_W-1:0];

  // Outs of window w live in the ins slot of window w-1 (mod NWIN).
  always_comb begin
    win      = cwp;
    is_local = 1'b0;
    case (grp)
      GRP_OUT: win      = (cwp == '0) ? WW'(NWIN - 1) : cwp - WW'(1);
      GRP_LOC: is_local = 1'b1;
      default: win      = cwp;
    endcase
  end

  always_comb begin
    if (grp == GRP_GLOB) begin
      paddr = PW'(off);
    end else begin
      paddr = PW'(NGRP) + PW'(win) * PW'(2 * NGRP)
            + (is_local ? PW'(NGRP) : PW'(0)) + PW'(off);
    end
  end

endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN = 4,
  parameter int WW   = 2,
  parameter int OW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [WW-1:0] cwp,
  output logic [OW-1:0] occ,
  output logic          ovf,
  output logic          unf
);

  logic [WW-1:0] cwp_q, cwp_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          move_en;

  always_comb begin
    cwp_d   = cwp_q;
    occ_d   = occ_q;
    ovf     = 1'b0;
    unf     = 1'b0;
    move_en = 1'b0;
    if (call_i && !ret_i) begin
      if (occ_q == OW'(NWIN)) begin
        ovf = 1'b1;
      end else begin
        move_en = 1'b1;
        cwp_d   = (cwp_q == '0) ? WW'(NWIN - 1) : cwp_q - WW'(1);
        occ_d   = occ_q + OW'(1);
      end
    end else if (ret_i && !call_i) begin
      if (occ_q == OW'(1)) begin
        unf = 1'b1;
      end else begin
        move_en = 1'b1;
        cwp_d   = (cwp_q == WW'(NWIN - 1)) ? '0 : cwp_q + WW'(1);
        occ_d   = occ_q - OW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      occ_q <= OW'(1);
    end else if (move_en) begin
      cwp_q <= cwp_d;
      occ_q <= occ_d;
    end
  end

  assign cwp = cwp_q;
  assign occ = occ_q;

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int PHYS = 72,
  parameter int PW   = 7,
  parameter int DW   = 32,
  parameter int NRD  = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);

  logic [DW-1:0] view [PHYS];

  for (genvar i = 0; i < PHYS; i++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic          ent_en;
    assign ent_en = we && (waddr == PW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) begin
        ent_q <= wdata;
      end
    end
    assign view[i] = ent_q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hit;
    assign hit      = we && (waddr == raddr[p]);
    assign rdata[p] = hit ? wdata : view[raddr[p]];
  end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int NGRP = 8,
  parameter int DW   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          call_i,
  input  logic                          ret_i,
  input  logic                          wr_en,
  input  logic [$clog2(NGRP)+1:0]       wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic [$clog2(NGRP)+1:0]       rd0_addr,
  output logic [DW-1:0]                 rd0_data,
  input  logic [$clog2(NGRP)+1:0]       rd1_addr,
  output logic [DW-1:0]                 rd1_data,
  output logic                          ovf_trap,
  output logic                          unf_trap,
  output logic [$clog2(NWIN)-1:0]       cwp_o
);

  localparam int LW   = $clog2(NGRP) + 2;
  localparam int WW   = $clog2(NWIN);
  localparam int OW   = $clog2(NWIN + 1);
  localparam int PHYS = NGRP + NWIN * 2 * NGRP;
  localparam int PW   = $clog2(PHYS);
  localparam int NRD  = 2;
  localparam int NMAP = NRD + 1;

  logic          rst_q_n;
  logic [WW-1:0] cwp;
  logic [OW-1:0] win_occ;
  logic [LW-1:0] map_l [NMAP];
  logic [PW-1:0] map_p [NMAP];
  logic [PW-1:0] rd_p  [NRD];
  logic [DW-1:0] rd_d  [NRD];

  regwin_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  regwin_ptr #(.NWIN(NWIN), .WW(WW), .OW(OW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .call_i (call_i),
    .ret_i  (ret_i),
    .cwp    (cwp),
    .occ    (win_occ),
    .ovf    (ovf_trap),
    .unf    (unf_trap)
  );

  // Index 0 and 1 are the read ports, index NRD is the write port.
  assign map_l[0]   = rd0_addr;
  assign map_l[1]   = rd1_addr;
  assign map_l[NRD] = wr_addr;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    regwin_map #(.NWIN(NWIN), .NGRP(NGRP), .LW(LW), .PW(PW), .WW(WW)) u_map (
      .cwp   (cwp),
      .laddr (map_l[m]),
      .paddr (map_p[m])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rp
    assign rd_p[r] = map_p[r];
  end

  regwin_store #(.PHYS(PHYS), .PW(PW), .DW(DW), .NRD(NRD)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (map_p[NRD]),
    .wdata (wr_data),
    .raddr (rd_p),
    .rdata (rd_d)
  );

  assign rd0_data = rd_d[0];
  assign rd1_data = rd_d[1];
  assign cwp_o    = cwp;

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN = 4,
  parameter int LW   = 5,
  parameter int DW   = 32,
  parameter int WW   = 2,
  parameter int OW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          ret_i,
  input logic          wr_en,
  input logic [LW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [LW-1:0] rd0_addr,
  input logic [DW-1:0] rd0_data,
  input logic          ovf_trap,
  input logic          unf_trap,
  input logic [WW-1:0] cwp_o,
  input logic [OW-1:0] occ
);

  // R4: an accepted call moves the pointer down by one, modulo NWIN
  a_r4_call_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !ovf_trap) |=>
      (cwp_o == (($past(cwp_o) == '0) ? WW'(NWIN - 1) : $past(cwp_o) - WW'(1))));

  // R4: an accepted return moves the pointer up by one, modulo NWIN
  a_r4_ret_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !unf_trap) |=>
      (cwp_o == (($past(cwp_o) == WW'(NWIN - 1)) ? '0 : $past(cwp_o) + WW'(1))));

  // R6: overflow only with a full file, and nothing moves
  a_r6_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (occ == OW'(NWIN)));
  a_r6_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> ($stable(cwp_o) && $stable(occ)));

  // R7: underflow only with one frame, and nothing moves
  a_r7_unf_when_last: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |-> (occ == OW'(1)));
  a_r7_unf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |=> ($stable(cwp_o) && $stable(occ)));

  // R8: simultaneous call and return do nothing
  a_r8_both_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> (!ovf_trap && !unf_trap));
  a_r8_both_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(cwp_o));

  // R5: occupancy stays within its legal range
  a_r5_occ_range: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= OW'(1)) && (occ <= OW'(NWIN)));

  // R9: same-cycle write is visible on read port 0
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == rd0_addr)) |-> (rd0_data == wr_data));

endmodule

bind regwin_file regwin_file_chk #(
  .NWIN(NWIN), .LW(LW), .DW(DW), .WW(WW), .OW(OW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .call_i   (call_i),
  .ret_i    (ret_i),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd0_addr (rd0_addr),
  .rd0_data (rd0_data),
  .ovf_trap (ovf_trap),
  .unf_trap (unf_trap),
  .cwp_o    (cwp_o),
  .occ      (win_occ)
);

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, wr_en;
  logic [4:0]  wr_addr, rd0_addr, rd1_addr;
  logic [31:0] wr_data, rd0_data, rd1_data;
  logic        ovf_trap, unf_trap;
  logic [1:0]  cwp_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    bit          c0;
    logic [31:0] e0;
    bit          c1;
    logic [31:0] e1;
    bit          ct;
    bit          eo;
    bit          eu;
    bit          cw;
    logic [1:0]  ew;
    string       req;
  } item_t;

  item_t sb_q[$];

  always #2 clk = ~clk;

  regwin_file i_regwin_file (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .cwp_o(cwp_o)
  );

  function automatic item_t blank(input string req);
    item_t it;
    it.c0 = 0; it.e0 = '0; it.c1 = 0; it.e1 = '0;
    it.ct = 0; it.eo = 0;  it.eu = 0; it.cw = 0; it.ew = '0;
    it.req = req;
    return it;
  endfunction

  // Driver: applies one cycle of stimulus and queues what that cycle must show.
  task automatic drive(input bit c, input bit r, input bit we, input logic [4:0] wa,
                       input logic [31:0] wd, input logic [4:0] a0, input logic [4:0] a1,
                       input item_t it);
    @(posedge clk); #1;
    call_i = c; ret_i = r; wr_en = we; wr_addr = wa; wr_data = wd;
    rd0_addr = a0; rd1_addr = a1;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.c0) begin
        checks++;
        if (rd0_data !== it.e0) begin
          failures++;
          $display("FAIL %s rd0 actual=%h expected=%h", it.req, rd0_data, it.e0);
        end
      end
      if (it.c1) begin
        checks++;
        if (rd1_data !== it.e1) begin
          failures++;
          $display("FAIL %s rd1 actual=%h expected=%h", it.req, rd1_data, it.e1);
        end
      end
      if (it.ct) begin
        checks++;
        if (ovf_trap !== it.eo || unf_trap !== it.eu) begin
          failures++;
          $display("FAIL %s traps actual=%b%b expected=%b%b", it.req,
                   ovf_trap, unf_trap, it.eo, it.eu);
        end
      end
      if (it.cw) begin
        checks++;
        if (cwp_o !== it.ew) begin
          failures++;
          $display("FAIL %s cwp actual=%0d expected=%0d", it.req, cwp_o, it.ew);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [31:0] VG = 32'hA1A1_0001;
  localparam logic [31:0] VO = 32'h0E0E_0000;
  localparam logic [31:0] VL = 32'h10C0_0000;
  localparam logic [31:0] VP = 32'h0E0E_0001;
  localparam logic [31:0] VL3 = 32'h10C0_0003;

  initial begin
    item_t it;
    rst_n = 1'b0; call_i = 0; ret_i = 0; wr_en = 0;
    wr_addr = '0; wr_data = '0; rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R5: reset state
    it = blank("R5"); it.cw = 1; it.ew = 2'd0; it.ct = 1;
    drive(0, 0, 0, 0, 0, 0, 0, it);

    // R9: write global 1 and read it in the same cycle
    it = blank("R9"); it.c0 = 1; it.e0 = VG;
    drive(0, 0, 1, 5'd1, VG, 5'd1, 5'd0, it);

    // R1: stored global reads back
    it = blank("R1"); it.c0 = 1; it.e0 = VG;
    drive(0, 0, 1, 5'd8, VO, 5'd1, 5'd0, it);

    // R11: out 0 from storage on port 0, local 0 bypassed on port 1
    it = blank("R11"); it.c0 = 1; it.e0 = VO; it.c1 = 1; it.e1 = VL;
    drive(0, 0, 1, 5'd16, VL, 5'd8, 5'd16, it);

    // R10: write out 1 in the call cycle, still in window 0
    it = blank("R10"); it.c0 = 1; it.e0 = VP; it.ct = 1;
    drive(1, 0, 1, 5'd9, VP, 5'd9, 5'd0, it);

    // R4 and R3: callee window 3 sees caller outs as its ins
    it = blank("R3"); it.cw = 1; it.ew = 2'd3; it.c0 = 1; it.e0 = VO; it.c1 = 1; it.e1 = VP;
    drive(0, 0, 1, 5'd16, VL3, 5'd24, 5'd25, it);

    // R1: global visible in window 3, R2 local of window 3
    it = blank("R1"); it.c0 = 1; it.e0 = VG; it.c1 = 1; it.e1 = VL3;
    drive(0, 0, 0, 0, 0, 5'd1, 5'd16, it);

    // R10: read in the return cycle still uses window 3
    it = blank("R10"); it.c0 = 1; it.e0 = VL3;
    drive(0, 1, 0, 0, 0, 5'd16, 5'd0, it);

    // R2: back in window 0, local 0 unchanged by the callee
    it = blank("R2"); it.cw = 1; it.ew = 2'd0; it.c0 = 1; it.e0 = VL; it.c1 = 1; it.e1 = VO;
    drive(0, 0, 0, 0, 0, 5'd16, 5'd8, it);

    // R4: three calls wrap 0 -> 3 -> 2 -> 1
    it = blank("R4"); it.cw = 1; it.ew = 2'd0;
    drive(1, 0, 0, 0, 0, 0, 0, it);
    it = blank("R4"); it.cw = 1; it.ew = 2'd3;
    drive(1, 0, 0, 0, 0, 0, 0, it);
    it = blank("R4"); it.cw = 1; it.ew = 2'd2;
    drive(1, 0, 0, 0, 0, 0, 0, it);

    // R6: fourth frame pending; call overflows
    it = blank("R6"); it.cw = 1; it.ew = 2'd1; it.ct = 1; it.eo = 1;
    drive(1, 0, 0, 0, 0, 0, 0, it);

    // R6: pointer unchanged; R8: both strobes do nothing
    it = blank("R8"); it.cw = 1; it.ew = 2'd1; it.ct = 1;
    drive(1, 1, 0, 0, 0, 0, 0, it);

    // R8: pointer still 1; returns begin
    it = blank("R8"); it.cw = 1; it.ew = 2'd1;
    drive(0, 1, 0, 0, 0, 0, 0, it);
    it = blank("R4"); it.cw = 1; it.ew = 2'd2;
    drive(0, 1, 0, 0, 0, 0, 0, it);
    it = blank("R4"); it.cw = 1; it.ew = 2'd3;
    drive(0, 1, 0, 0, 0, 0, 0, it);

    // R7: only one frame left; return underflows
    it = blank("R7"); it.cw = 1; it.ew = 2'd0; it.ct = 1; it.eu = 1;
    drive(0, 1, 0, 0, 0, 0, 0, it);

    // R7: pointer unchanged and window 0 contents intact
    it = blank("R7"); it.cw = 1; it.ew = 2'd0; it.ct = 1; it.c0 = 1; it.e0 = VL;
    it.c1 = 1; it.e1 = VO;
    drive(0, 0, 0, 0, 0, 5'd16, 5'd8, it);

    @(posedge clk); #1;
    call_i = 0; ret_i = 0; wr_en = 0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule